// File: doc/BRIEF.md
# Circular stack pointer with limit checks

This block keeps the pointer for a stack memory that may be divided into sub-stacks. Push and pop strobes move the pointer, and the block presents the address the memory must access in that cycle, together with a write strobe or a read strobe. The pointer wraps circularly inside the sub-stack it currently points into. The most significant pointer bit picks the half of memory in use. A layout bit picks whether the wrap window is 128 or 64 locations wide.

Three limit addresses are built from the pointer's top bit and from fields of two limit registers: an overflow limit, an underflow threshold and a fatal address. Each access is compared with these limits. A hit raises one of three sticky error flags, which one depending on the kind of access. The flags are registered and stay set until software writes the pointer register again. Software reaches the pointer register and both limit registers through one register write port.

Top module: `circ_stack_ptr`

## Requirements
- R1: After reset the pointer and both limit registers are zero, all three error flags are low, and `mem_addr_o` shows 0x00 with both strobes low.
- R2: A push (push_i alone, no pointer write) raises `mem_we_o` and puts the current pointer on `mem_addr_o`. The pointer then advances by one. With no accepted access, `mem_addr_o` shows the pointer.
- R3: A pop (pop_i alone, no pointer write) first steps the pointer back by one. It raises `mem_re_o` and puts that decremented value on `mem_addr_o`, and the pointer keeps it.
- R4: Wrapping follows underflow-register bit 9. When it is 0, the pointer wraps within 128 locations and keeps bit 7. When it is 1, the pointer wraps within 64 locations and keeps bits 7:6. Stepping past the top of the window lands on its bottom, and stepping below the bottom lands on its top.
- R5: The overflow flag is set when a push accesses the overflow limit. In 128 mode that limit is {ptr[7], ovf[14:8]}. In 64 mode it is {ptr[7], b6, ovf[13:8]}, where b6 = ovf[14] ? unf[8] : 0.
- R6: The underflow flag is set when a pop accesses an address below {ptr[7], 2'b00, unf[15:11]}, compared unsigned. A push never sets it.
- R7: The fatal flag is set when a push or a pop accesses the fatal address {unf[10] | ptr[7], f6, 6'b111111}. f6 is 1 in 128 mode and (~ovf[14] | unf[8]) in 64 mode.
- R8: Error flags stay set until a pointer-register write, which clears all three. Writes to the limit registers leave them unchanged.
- R9: When push_i and pop_i are both high, the request is rejected. Both strobes stay low, and the pointer and the flags are unchanged.
- R10: A pointer-register write (reg_sel_i = 0) in the same cycle as push_i or pop_i wins. No strobe is raised, and the pointer takes reg_wdata_i[7:0]. reg_sel_i = 1 selects the overflow-limit register and 2 selects the underflow-limit register.
- R11: Flags are registered. A flag caused by an access shows up in the cycle after that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select: 0 pointer, 1 overflow limit, 2 underflow limit, 3 none |
| reg_wdata_i | input | 16 | Register write data |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| mem_addr_o | output | 8 | Stack memory address (pointer when idle) |
| mem_we_o | output | 1 | Stack memory write strobe (accepted push) |
| mem_re_o | output | 1 | Stack memory read strobe (accepted pop) |
| ovf_err_o | output | 1 | Sticky overflow flag |
| unf_err_o | output | 1 | Sticky underflow flag |
| fatal_err_o | output | 1 | Sticky fatal flag |

## Verification
The bench builds the block with the default 8-bit address, which gives 16-bit limit registers. At that size every wrap boundary and every limit address can be reached in a few pushes from a written pointer. Each address bit is therefore exercised directly: both halves, both window sizes, the cleared-bit-6 fatal case and the forced-high fatal top bit. Underflow is probed just at and just below the threshold.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_OVF  = 2'd1,
    SEL_UNF  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int NUM_ERR = 3;
  localparam int ERR_OVF = 0;
  localparam int ERR_UNF = 1;
  localparam int ERR_FAT = 2;

  // bit positions inside the stored upper byte of the underflow register
  localparam int UF_SEL  = 0;
  localparam int UF_NAR  = 1;
  localparam int UF_FTOP = 2;
endpackage

// File: rtl/csp_step.sv
module csp_step #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              narrow_i,
  output logic [ADDR_W-1:0] inc_o,
  output logic [ADDR_W-1:0] dec_o
);
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] plus_one;
  logic [ADDR_W-1:0] minus_one;

  always_comb begin
    win_mask = narrow_i ? {2'b00, {(ADDR_W-2){1'b1}}} : {1'b0, {(ADDR_W-1){1'b1}}};
    plus_one  = ptr_i + ADDR_W'(1);
    minus_one = ptr_i - ADDR_W'(1);
    inc_o = (ptr_i & ~win_mask) | (plus_one & win_mask);
    dec_o = (ptr_i & ~win_mask) | (minus_one & win_mask);
  end
endmodule

// File: rtl/csp_limits.sv
module csp_limits import csp_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              ptr_top_i,
  input  logic [ADDR_W-2:0] ovf_f_i,
  input  logic [ADDR_W-1:0] unf_f_i,
  output logic              narrow_o,
  output logic [ADDR_W-1:0] ovf_lim_o,
  output logic [ADDR_W-1:0] unf_lim_o,
  output logic [ADDR_W-1:0] fat_lim_o
);
  localparam int THR_W = ADDR_W - 3;

  logic b6_sel;
  logic fat_b6;
  logic fat_top;

  always_comb begin
    narrow_o = unf_f_i[UF_NAR];
    b6_sel   = ovf_f_i[ADDR_W-2] ? unf_f_i[UF_SEL] : 1'b0;
    if (narrow_o) ovf_lim_o = {ptr_top_i, b6_sel, ovf_f_i[ADDR_W-3:0]};
    else          ovf_lim_o = {ptr_top_i, ovf_f_i};
    unf_lim_o = {ptr_top_i, 2'b00, unf_f_i[ADDR_W-1 -: THR_W]};
    fat_top   = unf_f_i[UF_FTOP] | ptr_top_i;
    fat_b6    = narrow_o ? (~ovf_f_i[ADDR_W-2] | unf_f_i[UF_SEL]) : 1'b1;
    fat_lim_o = {fat_top, fat_b6, {(ADDR_W-2){1'b1}}};
  end
endmodule

// File: rtl/csp_sticky.sv
module csp_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/circ_stack_ptr.sv
module circ_stack_ptr import csp_pkg::*; #(
  parameter  int ADDR_W = 8,
  localparam int REG_W  = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              ovf_err_o,
  output logic              unf_err_o,
  output logic              fatal_err_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-2:0] ovf_f_q;   // overflow register bits REG_W-2 .. ADDR_W
  logic [ADDR_W-1:0] unf_f_q;   // underflow register bits REG_W-1 .. ADDR_W

  logic              ptr_wr;
  logic              acc_ok, do_push, do_pop;
  logic              narrow;
  logic [ADDR_W-1:0] ptr_inc, ptr_dec;
  logic [ADDR_W-1:0] ovf_lim, unf_lim, fat_lim;
  logic [NUM_ERR-1:0] err_set, err_q;

  assign ptr_wr  = reg_we_i && (reg_sel_i == SEL_PTR);
  assign acc_ok  = !ptr_wr && (push_i ^ pop_i);
  assign do_push = acc_ok && push_i;
  assign do_pop  = acc_ok && pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      ovf_f_q <= '0;
      unf_f_q <= '0;
    end else begin
      if (ptr_wr)       ptr_q <= reg_wdata_i[ADDR_W-1:0];
      else if (do_push) ptr_q <= ptr_inc;
      else if (do_pop)  ptr_q <= ptr_dec;
      if (reg_we_i && reg_sel_i == SEL_OVF) ovf_f_q <= reg_wdata_i[REG_W-2:ADDR_W];
      if (reg_we_i && reg_sel_i == SEL_UNF) unf_f_q <= reg_wdata_i[REG_W-1:ADDR_W];
    end
  end

  csp_step #(.ADDR_W(ADDR_W)) u_step (
    .ptr_i    (ptr_q),
    .narrow_i (narrow),
    .inc_o    (ptr_inc),
    .dec_o    (ptr_dec)
  );

  csp_limits #(.ADDR_W(ADDR_W)) u_limits (
    .ptr_top_i (ptr_q[ADDR_W-1]),
    .ovf_f_i   (ovf_f_q),
    .unf_f_i   (unf_f_q),
    .narrow_o  (narrow),
    .ovf_lim_o (ovf_lim),
    .unf_lim_o (unf_lim),
    .fat_lim_o (fat_lim)
  );

  assign mem_addr_o = do_pop ? ptr_dec : ptr_q;
  assign mem_we_o   = do_push;
  assign mem_re_o   = do_pop;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVF] = do_push && (mem_addr_o == ovf_lim);
    err_set[ERR_UNF] = do_pop  && (mem_addr_o <  unf_lim);
    err_set[ERR_FAT] = acc_ok  && (mem_addr_o == fat_lim);
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    csp_sticky u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set[g]),
      .clr_i  (ptr_wr),
      .q_o    (err_q[g])
    );
  end

  assign ovf_err_o   = err_q[ERR_OVF];
  assign unf_err_o   = err_q[ERR_UNF];
  assign fatal_err_o = err_q[ERR_FAT];
endmodule

// File: rtl/circ_stack_ptr_chk.sv
module circ_stack_ptr_chk import csp_pkg::*; #(
  parameter  int ADDR_W = 8,
  localparam int REG_W  = 2 * ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              ovf_err_o,
  input logic              unf_err_o,
  input logic              fatal_err_o
);
  logic ptr_wr;
  assign ptr_wr = reg_we_i && (reg_sel_i == SEL_PTR);

  assert_both_rejected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |-> (!mem_we_o && !mem_re_o));

  assert_strobes_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o}));

  assert_ptr_wr_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |-> (!mem_we_o && !mem_re_o));

  assert_clear_on_ptr_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> (!ovf_err_o && !unf_err_o && !fatal_err_o));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_err_o && !ptr_wr) |=> ovf_err_o);

  assert_unf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_err_o && !ptr_wr) |=> unf_err_o);

  assert_fat_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_err_o && !ptr_wr) |=> fatal_err_o);

  assert_push_no_unf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unf_err_o && !mem_re_o) |=> !unf_err_o);

  assert_ovf_after_push_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_err_o && !mem_we_o) |=> !ovf_err_o);

  assert_fat_after_access_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fatal_err_o && !mem_we_o && !mem_re_o) |=> !fatal_err_o);
endmodule

bind circ_stack_ptr circ_stack_ptr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/circ_stack_ptr_tb_top.sv
module circ_stack_ptr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [15:0] reg_wdata = '0;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_we, mem_re, ovf_err, unf_err, fat_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  circ_stack_ptr dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .push_i      (push),
    .pop_i       (pop),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .ovf_err_o   (ovf_err),
    .unf_err_o   (unf_err),
    .fatal_err_o (fat_err)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  // one access cycle: check address and strobes before the edge
  task automatic access(input logic p, input logic q, input logic [7:0] exp_addr,
                        input logic exp_we, input logic exp_re, input string tag);
    push = p; pop = q;
    #1;
    check(16'(mem_addr), 16'(exp_addr), {tag, " addr"});
    check(16'({mem_we, mem_re}), 16'({exp_we, exp_re}), {tag, " strobes"});
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic idle_chk(input logic [7:0] exp_addr, input logic eo, input logic eu,
                          input logic ef, input string tag);
    #1;
    check(16'(mem_addr), 16'(exp_addr), {tag, " idle addr"});
    check(16'({ovf_err, unf_err, fat_err}), 16'({eo, eu, ef}), {tag, " flags ovf/unf/fat"});
  endtask

  task automatic t_reset;
    idle_chk(8'h00, 1'b0, 1'b0, 1'b0, "R1 reset");
    check(16'({mem_we, mem_re}), 16'h0, "R1 reset strobes");
  endtask

  task automatic t_push_pop;
    wr_reg(2'd1, 16'h3F00);
    wr_reg(2'd0, 16'h0010);
    access(1'b1, 1'b0, 8'h10, 1'b1, 1'b0, "R2 push");
    idle_chk(8'h11, 1'b0, 1'b0, 1'b0, "R2 after push");
    access(1'b0, 1'b1, 8'h10, 1'b0, 1'b1, "R3 pop");
    idle_chk(8'h10, 1'b0, 1'b0, 1'b0, "R3 after pop");
  endtask

  task automatic t_wrap128;
    wr_reg(2'd1, 16'h4000);
    wr_reg(2'd2, 16'h0000);
    wr_reg(2'd0, 16'h00FF);
    access(1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, "R4 push top of upper half");
    idle_chk(8'h80, 1'b0, 1'b0, 1'b1, "R4/R7 wrap to 0x80 and fatal");
    access(1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, "R4 pop wraps to top");
    idle_chk(8'hFF, 1'b0, 1'b0, 1'b1, "R4 after pop");
    wr_reg(2'd1, 16'h3F00);
    idle_chk(8'hFF, 1'b0, 1'b0, 1'b1, "R8 limit write keeps flag");
    wr_reg(2'd0, 16'h0020);
    idle_chk(8'h20, 1'b0, 1'b0, 1'b0, "R8 pointer write clears");
  endtask

  task automatic t_overflow;
    wr_reg(2'd0, 16'h003E);
    access(1'b1, 1'b0, 8'h3E, 1'b1, 1'b0, "R5 push below limit");
    idle_chk(8'h3F, 1'b0, 1'b0, 1'b0, "R5 no overflow yet");
    push = 1'b1;
    #1;
    check(16'(ovf_err), 16'h0, "R11 flag not yet visible");
    @(negedge clk);
    push = 1'b0;
    idle_chk(8'h40, 1'b1, 1'b0, 1'b0, "R5/R11 overflow at 0x3F");
  endtask

  task automatic t_underflow;
    wr_reg(2'd2, 16'h4000);
    wr_reg(2'd0, 16'h0002);
    access(1'b1, 1'b0, 8'h02, 1'b1, 1'b0, "R6 push below threshold");
    idle_chk(8'h03, 1'b0, 1'b0, 1'b0, "R6 push sets no underflow");
    wr_reg(2'd0, 16'h0009);
    access(1'b0, 1'b1, 8'h08, 1'b0, 1'b1, "R6 pop at threshold");
    idle_chk(8'h08, 1'b0, 1'b0, 1'b0, "R6 at threshold no flag");
    access(1'b0, 1'b1, 8'h07, 1'b0, 1'b1, "R6 pop below threshold");
    idle_chk(8'h07, 1'b0, 1'b1, 1'b0, "R6 underflow set");
  endtask

  task automatic t_narrow;
    wr_reg(2'd2, 16'h0200);
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd0, 16'h007F);
    access(1'b1, 1'b0, 8'h7F, 1'b1, 1'b0, "R4 push top of 64 window");
    idle_chk(8'h40, 1'b0, 1'b0, 1'b1, "R4/R7 64 wrap and fatal");
    access(1'b0, 1'b1, 8'h7F, 1'b0, 1'b1, "R4 pop wraps in 64 window");
    wr_reg(2'd1, 16'h4000);
    wr_reg(2'd0, 16'h003F);
    access(1'b1, 1'b0, 8'h3F, 1'b1, 1'b0, "R7 push at fatal with bit6 clear");
    idle_chk(8'h00, 1'b0, 1'b0, 1'b1, "R7 fatal 0x3F");
    access(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R5 push at 0x00");
    idle_chk(8'h01, 1'b1, 1'b0, 1'b1, "R5 overflow bit6 from select=0");
    wr_reg(2'd2, 16'h0300);
    wr_reg(2'd0, 16'h0040);
    access(1'b1, 1'b0, 8'h40, 1'b1, 1'b0, "R5 push at 0x40");
    idle_chk(8'h41, 1'b1, 1'b0, 1'b0, "R5 overflow bit6 from select=1");
  endtask

  task automatic t_fatal_top;
    wr_reg(2'd2, 16'h0400);
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd0, 16'h007F);
    access(1'b1, 1'b0, 8'h7F, 1'b1, 1'b0, "R7 push at 0x7F");
    idle_chk(8'h00, 1'b0, 1'b0, 1'b0, "R7 forced top bit moves fatal");
    access(1'b0, 1'b1, 8'h7F, 1'b0, 1'b1, "R7 pop to 0x7F");
    idle_chk(8'h7F, 1'b0, 1'b0, 1'b0, "R7 no fatal on read");
  endtask

  task automatic t_conflict;
    wr_reg(2'd2, 16'h0000);
    wr_reg(2'd1, 16'h3F00);
    wr_reg(2'd0, 16'h0030);
    access(1'b1, 1'b1, 8'h30, 1'b0, 1'b0, "R9 push and pop together");
    idle_chk(8'h30, 1'b0, 1'b0, 1'b0, "R9 pointer unchanged");
  endtask

  task automatic t_priority;
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0055; push = 1'b1;
    #1;
    check(16'({mem_we, mem_re}), 16'h0, "R10 no strobe under pointer write");
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3; push = 1'b0;
    idle_chk(8'h55, 1'b0, 1'b0, 1'b0, "R10 pointer write wins");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_wrap128();
    t_overflow();
    t_underflow();
    t_narrow();
    t_fatal_top();
    t_conflict();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule